// File: doc/BRIEF.md
# SGRAM Command Decoder and Guard

This block sits on the device side of a two-bank synchronous graphics DRAM. It samples the command pins on every rising clock edge while chip select is low. The pins are row strobe, column strobe, write enable, the graphics special-function pin, bank select and the address lines. From them it forms a command. It keeps an idle or active flag for each bank. It holds the mode word, which carries CAS latency, addressing mode and burst length. After a block write with auto-precharge it applies a lockout window.

A command that breaks a rule is not applied. It raises a one-cycle error pulse, and the accepted-command output shows NOP for that cycle. The block has no streaming data path: the array, data lines, refresh and burst timing belong elsewhere. Every pin is a plain control or status signal, and no valid/ready back-pressure applies.

Pin codes in this brief are written {ras_n, cas_n, we_n, dsf}. When chip select is low and the three strobes are all high, the cycle is a NOP whatever dsf is.

Top module: `sgram_cmd_guard`

## Requirements
- R1: After reset every bank is idle, the mode word is marked invalid, and err, busy, acc_cmd and bw_col are all zero.
- R2: A cycle with cs_n high is a NOP. It changes no bank, mode or lockout state apart from the lockout countdown, and it raises no error.
- R3: While the mode word is invalid, any command other than NOP, precharge (0100) or mode set (0000) raises err and is ignored.
- R4: Mode set (0000) loads {bs, addr[8:0]} into mode_word, and the new value and mode_valid appear after that edge. The CAS-latency field is addr[6:4]. Only the values 1, 2 and 3 are accepted; any other value raises err and leaves the mode word unchanged.
- R5: Mode set is rejected with err while any bank is active or the lockout is running.
- R6: Activate (0110) marks the bank chosen by bs active if it is idle. Activating a bank that is already active raises err.
- R7: Read (1010) and write (1000) are accepted only when the bank chosen by bs is active; otherwise they raise err. Neither changes the bank state.
- R8: Precharge (0100) with addr[9] high idles both banks; with addr[9] low it idles the bank chosen by bs. Precharge of an idle bank is legal.
- R9: Block write (1011) needs the chosen bank active and loads bw_col from addr[7:3]. With addr[9] high it also starts a lockout of TBPL+TRP cycles on that bank. With addr[9] low the bank stays active and no lockout starts.
- R10: For the TBPL+TRP clock edges after an auto-precharging block write, busy is high and every non-NOP command raises err and is ignored. The bank becomes idle at the last edge of the window, and busy then falls.
- R11: Any other pin code, such as refresh (0010) or a code with dsf high other than block write, raises err. Every rejected command shows acc_cmd = 0 (NOP).
- R12: acc_cmd reports the accepted command, one cycle after its edge, with this encoding: 0 NOP, 1 activate, 2 precharge, 3 read, 4 write, 5 block write, 6 mode set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Graphics special-function pin |
| bs | input | 1 | Bank select |
| addr | input | 10 | Address lines; bit 9 selects auto-precharge or all banks |
| err | output | 1 | One-cycle pulse for a rejected command |
| acc_cmd | output | 3 | Code of the accepted command, 0 when none |
| bank_active | output | 2 | Active flag for each bank |
| busy | output | 1 | Lockout window running |
| mode_valid | output | 1 | Mode word has been loaded |
| mode_word | output | 10 | Stored mode word {bs, addr[8:0]} |
| cas_lat | output | 3 | CAS latency field of the mode word |
| bw_col | output | 5 | Column of the last accepted block write |

## Verification
Every result is registered, so err, acc_cmd, bank_active, mode_word, mode_valid and bw_col are due one cycle after the edge that samples a command. The bench drives the pins on the falling edge and compares 2 ns after the next rising edge, against a model it steps once per edge. The lockout is counted in edges: the command at the edge that loads the window is accepted. The next TBPL+TRP edges reject, and the bank idles at the last of them. The first command accepted after a block write is the one at the following edge, and the directed block-write sequence checks each of those edges.

// File: rtl/sgcmd_pkg.sv
package sgcmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_BW  = 3'd5,
    CMD_MRS = 3'd6,
    CMD_BAD = 3'd7
  } cmd_e;
endpackage

// File: rtl/sgcmd_decode.sv
module sgcmd_decode
  import sgcmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic dsf,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n || (ras_n && cas_n && we_n)) begin
      cmd = CMD_NOP;
    end else begin
      unique case ({ras_n, cas_n, we_n, dsf})
        4'b0110: cmd = CMD_ACT;
        4'b0100: cmd = CMD_PRE;
        4'b1010: cmd = CMD_RD;
        4'b1000: cmd = CMD_WR;
        4'b1011: cmd = CMD_BW;
        4'b0000: cmd = CMD_MRS;
        default: cmd = CMD_BAD;
      endcase
    end
  end
endmodule

// File: rtl/sgcmd_lockout.sv
module sgcmd_lockout #(
  parameter int LOCK  = 5,
  parameter int CNT_W = $clog2(LOCK + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(LOCK);
    end else if (busy) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sgcmd_modereg.sv
module sgcmd_modereg #(
  parameter int MODE_W = 10,
  parameter int CL_LSB = 4,
  parameter int CL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W-1:0] din,
  output logic [MODE_W-1:0] word,
  output logic              valid,
  output logic [CL_W-1:0]   cl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      valid <= 1'b0;
    end else if (we) begin
      word  <= din;
      valid <= 1'b1;
    end
  end

  assign cl = word[CL_LSB +: CL_W];
endmodule

// File: rtl/sgram_cmd_guard.sv
module sgram_cmd_guard
  import sgcmd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NBANK  = 2,
  parameter int TBPL   = 2,
  parameter int TRP    = 3,
  parameter int COL_LSB = 3,
  parameter int COL_W   = 5,
  parameter int CL_LSB  = 4,
  localparam int BS_W   = $clog2(NBANK),
  localparam int MODE_W = ADDR_W - 1 + BS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              dsf,
  input  logic [BS_W-1:0]   bs,
  input  logic [ADDR_W-1:0] addr,
  output logic              err,
  output logic [2:0]        acc_cmd,
  output logic [NBANK-1:0]  bank_active,
  output logic              busy,
  output logic              mode_valid,
  output logic [MODE_W-1:0] mode_word,
  output logic [2:0]        cas_lat,
  output logic [COL_W-1:0]  bw_col
);
  localparam int LOCK   = TBPL + TRP;
  localparam int CNT_W  = $clog2(LOCK + 1);
  localparam int AP_BIT = ADDR_W - 1;

  cmd_e cmd;
  sgcmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dsf(dsf), .cmd(cmd)
  );

  logic lk_load, lk_done;
  sgcmd_lockout #(.LOCK(LOCK), .CNT_W(CNT_W)) u_lk (
    .clk(clk), .rst_n(rst_n), .load(lk_load), .busy(busy), .done(lk_done)
  );

  logic [MODE_W-1:0] mw_in;
  logic [2:0]        cl_in;
  logic              mr_we;
  assign mw_in = {bs, addr[ADDR_W-2:0]};
  assign cl_in = mw_in[CL_LSB +: 3];

  sgcmd_modereg #(.MODE_W(MODE_W), .CL_LSB(CL_LSB), .CL_W(3)) u_mr (
    .clk(clk), .rst_n(rst_n), .we(mr_we), .din(mw_in),
    .word(mode_word), .valid(mode_valid), .cl(cas_lat)
  );

  // Legality of the sampled command
  logic ok;
  logic sel_act;
  assign sel_act = bank_active[bs];

  always_comb begin
    ok = 1'b0;
    if (cmd == CMD_NOP) begin
      ok = 1'b1;
    end else if (busy) begin
      ok = 1'b0;
    end else if (!mode_valid && cmd != CMD_PRE && cmd != CMD_MRS) begin
      ok = 1'b0;
    end else begin
      unique case (cmd)
        CMD_ACT: ok = !sel_act;
        CMD_PRE: ok = 1'b1;
        CMD_RD,
        CMD_WR,
        CMD_BW:  ok = sel_act;
        CMD_MRS: ok = (bank_active == '0) && (cl_in != 3'd0) && (cl_in <= 3'd3);
        default: ok = 1'b0;
      endcase
    end
  end

  assign lk_load = ok && (cmd == CMD_BW) && addr[AP_BIT];
  assign mr_we   = ok && (cmd == CMD_MRS);

  logic [BS_W-1:0] lk_bank;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_active[g] <= 1'b0;
      end else if (lk_done && lk_bank == BS_W'(g)) begin
        bank_active[g] <= 1'b0;
      end else if (ok && cmd == CMD_ACT && bs == BS_W'(g)) begin
        bank_active[g] <= 1'b1;
      end else if (ok && cmd == CMD_PRE && (addr[AP_BIT] || bs == BS_W'(g))) begin
        bank_active[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err     <= 1'b0;
      acc_cmd <= 3'd0;
      lk_bank <= '0;
      bw_col  <= '0;
    end else begin
      err     <= !ok;
      acc_cmd <= ok ? cmd : CMD_NOP;
      if (lk_load) lk_bank <= bs;
      if (ok && cmd == CMD_BW) bw_col <= addr[COL_LSB +: COL_W];
    end
  end
endmodule

// File: rtl/sgram_cmd_guard_chk.sv
module sgram_cmd_guard_chk #(
  parameter int NBANK  = 2,
  parameter int MODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              dsf,
  input logic              bs,
  input logic              err,
  input logic [2:0]        acc_cmd,
  input logic [NBANK-1:0]  bank_active,
  input logic              busy,
  input logic              mode_valid,
  input logic [MODE_W-1:0] mode_word,
  input logic [2:0]        cas_lat
);
  p_cs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !busy) |=> ($stable(bank_active) && $stable(mode_word) && $stable(mode_valid) && !err));

  p_idle_before_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_valid |-> (bank_active == '0));

  p_cl_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> (cas_lat != 3'd0 && cas_lat <= 3'd3));

  p_mrs_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_active != '0 || busy) |=> $stable(mode_word));

  p_act_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bank_active[0]) |-> $past(!cs_n && !ras_n && cas_n && we_n && !dsf && !bs));

  p_lock_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_n && !(ras_n && cas_n && we_n)) |=> err);

  p_rej_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (acc_cmd == 3'd0));
endmodule

bind sgram_cmd_guard sgram_cmd_guard_chk #(.NBANK(NBANK), .MODE_W(MODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .dsf(dsf), .bs(bs), .err(err), .acc_cmd(acc_cmd), .bank_active(bank_active),
  .busy(busy), .mode_valid(mode_valid), .mode_word(mode_word), .cas_lat(cas_lat)
);

// File: tb/sgram_cmd_guard_tb_top.sv
module sgram_cmd_guard_tb_top;
  localparam int LOCK = 5;  // TBPL 2 + TRP 3

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0, bs = 1'b0;
  logic [9:0] addr = '0;
  logic err, busy, mode_valid;
  logic [2:0] acc_cmd, cas_lat;
  logic [1:0] bank_active;
  logic [9:0] mode_word;
  logic [4:0] bw_col;

  always #4 clk = ~clk;

  sgram_cmd_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dsf(dsf), .bs(bs), .addr(addr), .err(err), .acc_cmd(acc_cmd),
    .bank_active(bank_active), .busy(busy), .mode_valid(mode_valid),
    .mode_word(mode_word), .cas_lat(cas_lat), .bw_col(bw_col)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [1:0] m_act = '0;
  logic       m_mv = 1'b0;
  logic [9:0] m_mw = '0;
  int         m_cnt = 0;
  logic       m_lkb = 1'b0;
  logic       m_err = 1'b0;
  logic [2:0] m_acc = '0;
  logic [4:0] m_col = '0;

  function automatic int classify(input logic c, r, a, w, d);
    if (c) return 0;
    if (r && a && w) return 0;
    case ({r, a, w, d})
      4'b0110: return 1;
      4'b0100: return 2;
      4'b1010: return 3;
      4'b1000: return 4;
      4'b1011: return 5;
      4'b0000: return 6;
      default: return 7;
    endcase
  endfunction

  // Steps the model for one edge and returns the requirement the cycle exercises
  function automatic string model_step(input logic c, r, a, w, d, b, input logic [9:0] ad);
    int k;
    logic good;
    string tag;
    k = classify(c, r, a, w, d);
    case (k)
      0: tag = "R2";
      1: tag = "R6";
      2: tag = "R8";
      3, 4: tag = "R7";
      5: tag = "R9";
      6: tag = "R4";
      default: tag = "R11";
    endcase
    if (k == 0) good = 1'b1;
    else if (m_cnt > 0) begin good = 1'b0; tag = "R10"; end
    else if (!m_mv && k != 2 && k != 6) begin good = 1'b0; tag = "R3"; end
    else if (k == 1) good = !m_act[b];
    else if (k == 2) good = 1'b1;
    else if (k == 3 || k == 4 || k == 5) good = m_act[b];
    else if (k == 6) begin
      if (m_act != 2'b00) begin good = 1'b0; tag = "R5"; end
      else good = (ad[6:4] >= 3'd1) && (ad[6:4] <= 3'd3);
    end else good = 1'b0;

    if (m_cnt == 1) m_act[m_lkb] = 1'b0;
    if (m_cnt > 0) m_cnt = m_cnt - 1;
    if (good) begin
      if (k == 1) m_act[b] = 1'b1;
      if (k == 2) begin
        if (ad[9]) m_act = 2'b00; else m_act[b] = 1'b0;
      end
      if (k == 5) begin
        m_col = ad[7:3];
        if (ad[9]) begin m_cnt = LOCK; m_lkb = b; end
      end
      if (k == 6) begin m_mw = {b, ad[8:0]}; m_mv = 1'b1; end
    end
    m_err = !good;
    m_acc = good ? 3'(k) : 3'd0;
    if (tag == "R7" && good && k == 4) tag = "R12";
    return tag;
  endfunction

  task automatic check_out(input string tag);
    logic [23:0] got, exp;
    got = {err, acc_cmd, bank_active, busy, mode_valid, mode_word, bw_col};
    exp = {m_err, m_acc, m_act, (m_cnt != 0), m_mv, m_mw, m_col};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, compare 2 ns after the next rising edge
  task automatic apply(input logic c, r, a, w, d, b, input logic [9:0] ad);
    string tag;
    cs_n = c; ras_n = r; cas_n = a; we_n = w; dsf = d; bs = b; addr = ad;
    tag = model_step(c, r, a, w, d, b, ad);
    @(posedge clk);
    #2;
    check_out(tag);
    @(negedge clk);
  endtask

  task automatic do_act(input logic b);      apply(0, 0, 1, 1, 0, b, 10'h000); endtask
  task automatic do_pre(input logic b, input logic all); apply(0, 0, 1, 0, 0, b, {all, 9'h000}); endtask
  task automatic do_rd(input logic b);       apply(0, 1, 0, 1, 0, b, 10'h000); endtask
  task automatic do_wr(input logic b);       apply(0, 1, 0, 0, 0, b, 10'h000); endtask
  task automatic do_bw(input logic b, input logic ap, input logic [4:0] col);
    apply(0, 1, 0, 1, 1, b, {ap, 1'b0, col, 3'b000});
  endtask
  task automatic do_mrs(input logic b, input logic [8:0] v); apply(0, 0, 0, 0, 0, b, {1'b0, v}); endtask
  task automatic do_nop();                   apply(0, 1, 1, 1, 0, 0, 10'h000); endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #13;
    // R1: reset state
    n_chk++;
    if ({err, acc_cmd, bank_active, busy, mode_valid, mode_word, bw_col} !== 24'h0) begin
      n_bad++;
      $display("FAIL R1: got %h expected 000000",
               {err, acc_cmd, bank_active, busy, mode_valid, mode_word, bw_col});
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    do_act(0);                      // R3 activate before mode set
    do_rd(1);                       // R3
    do_pre(0, 1);                   // R8 precharge allowed before mode set
    do_mrs(0, 9'h003);              // R4 CL 0 rejected
    do_mrs(1, 9'h047);              // R4 CL 4 rejected
    do_mrs(1, 9'h02B);              // R4 CL 2 accepted
    do_nop();
    apply(1, 0, 1, 1, 0, 0, 10'h0); // R2 deselected activate pins
    do_act(0);                      // R6
    do_act(0);                      // R6 double activate
    do_mrs(0, 9'h010);              // R5 bank active
    do_rd(1);                       // R7 idle bank
    do_wr(0);                       // R7 / R12
    apply(0, 0, 0, 1, 0, 0, 10'h0); // R11 refresh code
    apply(0, 0, 1, 1, 1, 0, 10'h0); // R11 dsf-high activate code
    do_bw(0, 0, 5'h15);             // R9 plain block write, no lockout
    do_bw(0, 1, 5'h0A);             // R9 auto-precharge block write
    for (int i = 0; i < LOCK; i++) do_act(1);  // R10 every window edge rejects
    do_act(1);                      // first edge after window accepts
    do_act(0);                      // bank 0 idle again
    do_pre(0, 1);                   // R8 all banks
    do_mrs(0, 9'h031);              // R4 CL 3

    for (int i = 0; i < 3000; i++) begin
      int op;
      logic b;
      logic [9:0] ad;
      op = $urandom_range(0, 9);
      b  = 1'($urandom_range(0, 1));
      ad = 10'($urandom);
      case (op)
        0: apply(1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), b, ad);
        1: do_nop();
        2, 9: do_act(b);
        3: do_pre(b, ($urandom_range(0, 3) == 0));
        4: if (ad[0]) do_rd(b); else do_wr(b);
        5: do_bw(b, ($urandom_range(0, 3) != 0), ad[7:3]);
        6: do_mrs(b, {ad[8:7], 3'($urandom_range(0, 4)), ad[3:0]});
        7: apply(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), b, ad);
        default: do_pre(b, 1'b1);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule